// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a 24-bit down-counter that produces a steady heartbeat for a scheduler or a delay loop. Software writes a reload value, clears the current value, then sets the enable bit. On each selected tick the counter steps down by one. When it reaches zero it raises a sticky count flag and, if enabled, an interrupt pulse. On the following tick it takes the reload value again. A reload value of N therefore gives one event every N+1 ticks.

The tick comes from one of two sources. The first is the core clock, one tick per cycle. The second is an external reference strobe, divided by eight inside the block. A debug-halt input freezes both the counter and the divider. Software reaches four word registers over a small single-cycle bus: control/status, reload, current value and a read-only calibration word. Read data is registered.

Top module: `tick_timer_top`

## Requirements
- R1: After reset every register reads zero except the calibration word, `bus_rdata` is zero and `irq` is low.
- R2: In core-clock mode (control bit 2 = 1, bit 0 = 1) the current value decreases by exactly one per clock cycle. With bit 0 = 0 it holds its value.
- R3: A tick that finds the counter at zero loads the reload value. With reload N, successive zero events are N+1 ticks apart.
- R4: Control bit 16 (count flag) is set when the counter steps from 1 to 0. It stays set until control word index 0 is read, and that read returns the flag before it clears. If a set and a read-clear happen in the same cycle, the set wins.
- R5: When control bit 1 = 1, `irq` is high for exactly one cycle, in the cycle after the step to zero. With bit 1 = 0 it stays low.
- R6: In reference mode (control bit 2 = 0) one tick is taken for every eighth `ref_stb` pulse while the timer is enabled. The divider restarts whenever the timer is disabled or core-clock mode is selected.
- R7: A write of any data to the current-value word (index 2) sets the counter to zero and clears the count flag. This write takes priority over a tick in the same cycle.
- R8: With reload 0 and the counter at zero, the counter stays at zero. The flag is not set and no `irq` occurs.
- R9: While `dbg_halt` = 1 the counter and the reference divider keep their values.
- R10: The calibration word (index 3) holds the ten-millisecond reload in bits 23:0, skew in bit 30 and no-reference in bit 31, and ignores writes. Reload keeps only bits 23:0. Unused bits of every word read as zero.
- R11: A read (`bus_sel`=1, `bus_we`=0) places the addressed word on `bus_rdata` one cycle later. Word index 0 is control, 1 is reload, 2 is current value and 3 is calibration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ref_stb | input | 1 | Reference tick strobe, one cycle wide |
| dbg_halt | input | 1 | Freezes counting while high |
| irq | output | 1 | One-cycle interrupt request at each zero step |

## Verification
A counter off by one in its step, or a reload taken on the wrong tick, changes the spacing between `irq` pulses. This shows within one period, and it also appears in the next read of word 2. A wrong divider phase in reference mode shifts every later zero event by a multiple of the strobe spacing, so the first pulse after the fault is already late or early. Flag errors stay invisible until control is read. The bench therefore reads it right after each zero event, and again straight after a clearing read or a current-value write.

// File: rtl/tick_pkg.sv
package tick_pkg;

    // Word index of each register on the bus
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_LOAD = 2'd1,
        REG_CUR  = 2'd2,
        REG_CAL  = 2'd3
    } reg_sel_e;

    // Bit positions inside the control/status word
    localparam int BIT_EN    = 0;
    localparam int BIT_IE    = 1;
    localparam int BIT_SRC   = 2;
    localparam int BIT_FLAG  = 16;
    // Bit positions inside the calibration word
    localparam int BIT_SKEW  = 30;
    localparam int BIT_NOREF = 31;

    localparam int BUS_W = 32;

    typedef struct packed {
        logic src;   // 1: core clock, 0: divided reference strobe
        logic ie;    // interrupt enable
        logic en;    // counter enable
    } ctrl_t;

endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic tick
);

    typedef struct packed {
        logic [DIV_LOG2-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.pre = '0;
        end else if (adv) begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A tick leaves on the strobe that wraps the divider
    assign tick = adv && (&st_q.pre);

    AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(st_q.pre)); // R9

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.pre == '0)); // R6

endmodule

// File: rtl/tick_core.sv
module tick_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cur_wr,
    input  logic             flag_rd_clr,
    input  logic             ie,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cur,
    output logic             flag,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic             flag;
        logic             irq;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     at_one;
    logic     at_zero;
    logic     hit_zero;

    assign at_one   = (st_q.cur == CNT_W'(1));
    assign at_zero  = (st_q.cur == '0);
    assign hit_zero = tick && at_one;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (cur_wr) begin
            st_d.cur  = '0;
            st_d.flag = 1'b0;
        end else begin
            if (tick) begin
                if (at_zero) begin
                    st_d.cur = reload;
                end else begin
                    st_d.cur = st_q.cur - 1'b1;
                end
            end
            if (hit_zero) begin
                st_d.flag = 1'b1;
                st_d.irq  = ie;
            end else if (flag_rd_clr) begin
                st_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur  = st_q.cur;
    assign flag = st_q.flag;
    assign irq  = st_q.irq;

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cur_wr && !at_zero) |=> (st_q.cur == $past(st_q.cur) - 1'b1)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cur_wr) |=> $stable(st_q.cur)); // R9

    AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cur_wr && at_zero) |=> (st_q.cur == $past(reload))); // R3

    AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cur_wr && at_one) |=> st_q.flag); // R4

    AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd_clr && !hit_zero) |=> !st_q.flag); // R4

    AST_CUR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (st_q.cur == '0 && !st_q.flag)); // R7

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq); // R5

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |=> !st_q.irq); // R5

endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int               CNT_W     = 24,
    parameter logic [CNT_W-1:0] CAL_TENMS = CNT_W'(89999),
    parameter logic             CAL_SKEW  = 1'b1,
    parameter logic             CAL_NOREF = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] cur_val,
    input  logic             flag_val,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload,
    output logic             cur_wr,
    output logic             ctrl_rd,
    output logic [BUS_W-1:0] rdata
);

    localparam int PAD_W = BUS_W - CNT_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
        logic [BUS_W-1:0] rdata;
    } reg_st_t;

    reg_st_t          st_d, st_q;
    reg_sel_e         sel;
    logic             rd_req;
    logic             wr_req;
    logic [BUS_W-1:0] rd_word;
    logic [BUS_W-1:0] cal_word;
    logic             wdata_unused;

    assign sel    = reg_sel_e'(bus_addr);
    assign rd_req = bus_sel && !bus_we;
    assign wr_req = bus_sel && bus_we;

    assign wdata_unused = ^bus_wdata[BUS_W-1:CNT_W];

    always_comb begin
        cal_word                           = '0;
        cal_word[CNT_W-1:0]                = CAL_TENMS;
        cal_word[BIT_SKEW]                 = CAL_SKEW;
        cal_word[BIT_NOREF]                = CAL_NOREF;
    end

    always_comb begin
        rd_word = '0;
        case (sel)
            REG_CTRL: begin
                rd_word[BIT_EN]   = st_q.ctrl.en;
                rd_word[BIT_IE]   = st_q.ctrl.ie;
                rd_word[BIT_SRC]  = st_q.ctrl.src;
                rd_word[BIT_FLAG] = flag_val;
            end
            REG_LOAD: rd_word = {{PAD_W{1'b0}}, st_q.reload};
            REG_CUR:  rd_word = {{PAD_W{1'b0}}, cur_val};
            default:  rd_word = cal_word;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rd_req) begin
            st_d.rdata = rd_word;
        end
        if (wr_req) begin
            case (sel)
                REG_CTRL: begin
                    st_d.ctrl.en  = bus_wdata[BIT_EN];
                    st_d.ctrl.ie  = bus_wdata[BIT_IE];
                    st_d.ctrl.src = bus_wdata[BIT_SRC];
                end
                REG_LOAD: st_d.reload = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl    = st_q.ctrl;
    assign reload  = st_q.reload;
    assign rdata   = st_q.rdata;
    assign cur_wr  = wr_req && (sel == REG_CUR);
    assign ctrl_rd = rd_req && (sel == REG_CTRL);

    AST_CAL_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel == REG_CAL) |=> (st_q.rdata[BIT_SKEW-1:CNT_W] == '0)); // R10

    AST_CTRL_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel == REG_CTRL)
        |=> (st_q.rdata[BIT_FLAG-1:BIT_SRC+1] == '0 && st_q.rdata[BUS_W-1:BIT_FLAG+1] == '0)); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(st_q.rdata)); // R11

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel == REG_CTRL) |=> (st_q.ctrl.en == $past(bus_wdata[BIT_EN]))); // R2

endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top
    import tick_pkg::*;
#(
    parameter int               CNT_W     = 24,
    parameter int               DIV_LOG2  = 3,
    parameter logic [CNT_W-1:0] CAL_TENMS = CNT_W'(89999),
    parameter logic             CAL_SKEW  = 1'b1,
    parameter logic             CAL_NOREF = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ref_stb,
    input  logic        dbg_halt,
    output logic        irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cur;
    logic             flag;
    logic             cur_wr;
    logic             ctrl_rd;
    logic             run;
    logic             pre_clr;
    logic             pre_adv;
    logic             pre_tick;
    logic             tick;

    assign run     = ctrl.en && !dbg_halt;
    assign pre_clr = !ctrl.en || ctrl.src;
    assign pre_adv = run && !ctrl.src && ref_stb;
    assign tick    = ctrl.src ? run : pre_tick;

    tick_regs #(
        .CNT_W     (CNT_W),
        .CAL_TENMS (CAL_TENMS),
        .CAL_SKEW  (CAL_SKEW),
        .CAL_NOREF (CAL_NOREF)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cur_val   (cur),
        .flag_val  (flag),
        .ctrl      (ctrl),
        .reload    (reload),
        .cur_wr    (cur_wr),
        .ctrl_rd   (ctrl_rd),
        .rdata     (bus_rdata)
    );

    tick_prescale #(
        .DIV_LOG2 (DIV_LOG2)
    ) i_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .adv   (pre_adv),
        .tick  (pre_tick)
    );

    tick_core #(
        .CNT_W (CNT_W)
    ) i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cur_wr      (cur_wr),
        .flag_rd_clr (ctrl_rd),
        .ie          (ctrl.ie),
        .reload      (reload),
        .cur         (cur),
        .flag        (flag),
        .irq         (irq)
    );

    AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_halt |-> !tick); // R9

    AST_DISABLED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> !tick); // R2

endmodule

// File: tb/test_tick_timer_top.sv
module test_tick_timer_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_stb = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        irq;

    localparam logic [31:0] CAL_EXP = 32'h4000_0000 | 32'd89999;

    int vectors = 0;
    int fails = 0;
    int ref_on = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    tick_timer_top i_tick_timer_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ref_stb   (ref_stb),
        .dbg_halt  (dbg_halt),
        .irq       (irq)
    );

    // ---------------- behavioural reference ----------------
    int          m_en, m_ie, m_src, m_flag, m_irq, m_pre;
    int          m_cur, m_rel;
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_word(input int a);
        case (a)
            0: return (m_en ? 32'h1 : 0) | (m_ie ? 32'h2 : 0) | (m_src ? 32'h4 : 0)
                      | (m_flag ? 32'h1_0000 : 0);
            1: return 32'(m_rel);
            2: return 32'(m_cur);
            default: return CAL_EXP;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0; m_pre = 0;
            m_cur = 0; m_rel = 0; m_rdata = '0;
        end else begin
            int tk, wcur, rclr, setf, a;
            a    = int'(bus_addr);
            tk   = m_en && !dbg_halt && (m_src ? 1 : (ref_stb && m_pre == 7));
            wcur = bus_sel && bus_we && a == 2;
            rclr = bus_sel && !bus_we && a == 0;
            setf = 0;
            if (bus_sel && !bus_we) m_rdata = m_word(a);
            m_irq = 0;
            if (!m_en || m_src) m_pre = 0;
            else if (!dbg_halt && ref_stb) m_pre = (m_pre + 1) % 8;
            if (wcur) begin
                m_cur = 0; m_flag = 0;
            end else begin
                if (tk) begin
                    if (m_cur == 0) m_cur = m_rel;
                    else begin
                        if (m_cur == 1) setf = 1;
                        m_cur = m_cur - 1;
                    end
                end
                if (setf) begin m_flag = 1; m_irq = m_ie; end
                else if (rclr) m_flag = 0;
            end
            if (bus_sel && bus_we && a == 0) begin
                m_en = bus_wdata[0]; m_ie = bus_wdata[1]; m_src = bus_wdata[2];
            end
            if (bus_sel && bus_we && a == 1) m_rel = int'(bus_wdata[23:0]);
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // cycle-by-cycle comparison against the reference, away from the edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R5 irq", {31'b0, irq}, 32'(m_irq));
            chk("R11 rdata", bus_rdata, m_rdata);
        end
    end

    // reference strobe: one pulse every third cycle when switched on
    always @(negedge clk) ref_stb <= (ref_on != 0) && (cyc % 3 == 0);

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // cycles between two consecutive irq pulses
    task automatic irq_gap(output int gap);
        gap = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (irq) begin gap = 0; break; end
        end
        if (gap == 0) begin
            for (int i = 1; i < 2000; i++) begin
                @(negedge clk);
                if (irq) begin gap = i; break; end
            end
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        int gap, cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(2'd1, v); chk("R1 reload", v, 32'h0);
        rd(2'd2, v); chk("R1 current", v, 32'h0);
        rd(2'd3, v); chk("R10 calibration", v, CAL_EXP);

        // R10: reload masked to 24 bits, calibration ignores writes
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R10 reload mask", v, 32'h00FF_FFFF);
        wr(2'd3, 32'h0);
        rd(2'd3, v); chk("R10 cal write ignored", v, CAL_EXP);

        // R2/R3/R5: core clock, reload 5
        wr(2'd1, 32'd5);
        wr(2'd2, 32'h1234);
        wr(2'd0, 32'h7);
        irq_gap(gap); chk("R3 period core", 32'(gap), 32'd6);
        rd(2'd2, v); rd(2'd2, v2); chk("R2 step per cycle", v - v2, 32'd2);
        idle(3);

        // R4: flag sticky, cleared by read
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R4 flag set", v & 32'h1_0000, 32'h1_0000);
        rd(2'd0, v); chk("R4 flag cleared by read", v & 32'h1_0000, 32'h0);
        rd(2'd2, v); rd(2'd2, v2); chk("R2 hold when disabled", v2, v);

        // R9: halt freezes counting
        wr(2'd1, 32'd100);
        wr(2'd0, 32'h5);
        idle(7);
        dbg_halt = 1'b1;
        idle(2);
        rd(2'd2, v); idle(5); rd(2'd2, v2); chk("R9 halt freezes", v2, v);
        dbg_halt = 1'b0;
        idle(4);

        // R7: current-value write clears counter and flag
        wr(2'd1, 32'd3);
        wr(2'd0, 32'h5);
        idle(10);
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hDEAD_BEEF);
        rd(2'd2, v); chk("R7 counter cleared", v, 32'h0);
        rd(2'd0, v); chk("R7 flag cleared", v & 32'h1_0000, 32'h0);

        // R5: interrupt masked when bit 1 is 0
        wr(2'd0, 32'h5);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (irq) cnt++; end
        chk("R5 masked irq", 32'(cnt), 32'h0);

        // R6: reference mode, strobe every 3 cycles, reload 3 -> 4 ticks * 8 strobes * 3
        wr(2'd0, 32'h0);
        ref_on = 1;
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h3);
        irq_gap(gap); chk("R6 period reference", 32'(gap), 32'd96);
        dbg_halt = 1'b1;
        idle(13);
        dbg_halt = 1'b0;
        idle(60);
        ref_on = 0;

        // R8: reload 0 keeps counter at zero, no flag, no irq
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);
        rd(2'd0, v);
        wr(2'd0, 32'h7);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (irq) cnt++; end
        chk("R8 no irq", 32'(cnt), 32'h0);
        rd(2'd2, v); chk("R8 stays zero", v, 32'h0);
        rd(2'd0, v); chk("R8 no flag", v, 32'h7);

        // R4: back-to-back flag reads with reload 1 (set may collide with clear)
        wr(2'd1, 32'd1);
        for (int i = 0; i < 6; i++) rd(2'd0, v);
        idle(5);

        finish_run();
    end

endmodule